// File: doc/BRIEF.md
# Vectored Interrupt Peripheral Interface

This block sits on a simple synchronous system bus as a read-only slave. It holds one received data word and asks a processor for service over a single shared interrupt line. A pulse on the data-in strobe latches the incoming word into the data register and raises the interrupt request. When the processor answers with the acknowledge line, the block drives its interrupt vector onto the shared read-data bus. The vector can be a full service-routine address or a short index into a table of routine addresses. The request stays up until the processor reads the data register. That read returns the word in the same cycle, and the request falls on the next clock edge.

A status word at the address after the data register reports two bits: whether a request is pending, and whether a new word replaced one that had not yet been read. The request logic is a two-state machine. `ST_IDLE` moves to `ST_PEND` on a strobe, via the transition *capture*. `ST_PEND` returns to `ST_IDLE` on a data-register read with no strobe in the same cycle, via the transition *consume*. `ST_PEND` stays in `ST_PEND` on a strobe, via the transition *refill*. Every other condition holds the current state. The block drives the bus only when it is selected, and its read-data output is zero whenever its output enable is low.

Top module: `vecirq_periph`

## Requirements
- R1: After reset, `irq_req` is 0, the data register reads 0 and the status word reads 0.
- R2: A `din_stb` pulse latches `din`. A later read at `BASE_ADDR` returns that word on `bus_rdata`, with `bus_oe` high in the same cycle as `bus_rd`.
- R3: `irq_req` is high from the clock edge that samples `din_stb`.
- R4: In full-vector mode (`USE_INDEX`=0), while `irq_ack` is high and a request is pending, `bus_oe` is 1 and `bus_rdata` equals `VECTOR_ADDR`.
- R5: In table-index mode (`USE_INDEX`=1), the acknowledge drives `TABLE_IDX`, zero-extended to the bus width, instead of the full vector.
- R6: `irq_ack` with no pending request leaves `bus_oe` at 0 and `bus_rdata` at 0.
- R7: A read at `BASE_ADDR` while a request is pending clears `irq_req` at the next clock edge.
- R8: A strobe while a request is pending, with no data read in the same cycle, overwrites the data register, keeps `irq_req` high and sets the overrun flag.
- R9: A strobe in the same cycle as a data read latches the new word and keeps the request pending, and it does not set the overrun flag.
- R10: The status word at `BASE_ADDR`+1 has bit 0 = overrun and bit 1 = pending, and all other bits are 0. Overrun stays set until reset, including across data reads.
- R11: A read at any address other than the two own addresses, or no read and no acknowledge at all, gives `bus_oe` = 0 and `bus_rdata` = 0.
- R12: A read at `BASE_ADDR` while `irq_ack` is high with a request pending returns the vector, not the data, and does not clear the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | DATA_W | Incoming data word |
| din_stb | input | 1 | Latch strobe for `din` |
| bus_addr | input | ADDR_W | System bus address |
| bus_rd | input | 1 | System bus read strobe |
| bus_rdata | output | DATA_W | Read data or interrupt vector, zero when not driving |
| bus_oe | output | 1 | High while the block drives `bus_rdata` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |

## Verification
The bench builds two copies of the block and drives both from the same stimulus. The first copy uses the default full-vector mode with a vector of 16. The second copy uses table-index mode with index 5 and a 4-bit index field. Running the two side by side lets one acknowledge cycle check both ways of encoding the vector. Both copies use an 8-bit data width and base address 0x8000, so the status bits and the zero-extension of the short index land at known positions on the bus.

// File: rtl/vip_pkg.sv
package vip_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } req_state_t;

    localparam int STAT_OVR_BIT  = 0;
    localparam int STAT_PEND_BIT = 1;
endpackage

// File: rtl/vip_req_fsm.sv
module vip_req_fsm
    import vip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din_stb,
    input  logic data_rd,
    output logic pending
);
    req_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (din_stb) state_d = ST_PEND;              // capture
            ST_PEND: begin
                if (din_stb)      state_d = ST_PEND;              // refill
                else if (data_rd) state_d = ST_IDLE;              // consume
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == ST_PEND);
    end

    // R3
    strobe_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_stb |=> pending);
    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && data_rd && !din_stb) |=> !pending);
endmodule

// File: rtl/vip_capture.sv
module vip_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_stb,
    input  logic              pending,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_q,
    output logic              overrun_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (din_stb) data_q <= din;
            if (din_stb && pending && !data_rd) overrun_q <= 1'b1;
        end
    end

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din_stb && pending && !data_rd) |=> overrun_q);
    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_q |=> overrun_q);
    // R9
    no_false_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun_q && !(din_stb && pending)) |=> !overrun_q);
endmodule

// File: rtl/vip_bus_drv.sv
module vip_bus_drv
    import vip_pkg::*;
#(
    parameter int                  DATA_W      = 8,
    parameter int                  ADDR_W      = 16,
    parameter logic [ADDR_W-1:0]   BASE_ADDR   = 16'h8000,
    parameter bit                  USE_INDEX   = 1'b0,
    parameter int                  VECTOR_ADDR = 16,
    parameter int                  IDX_W       = 4,
    parameter int                  TABLE_IDX   = 5
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              irq_ack,
    input  logic              pending,
    input  logic              overrun,
    input  logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    output logic              data_rd
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);

    logic [DATA_W-1:0] vec_word;
    logic [DATA_W-1:0] stat_word;
    logic              vec_sel;
    logic              hit_data;
    logic              hit_stat;

    generate
        if (USE_INDEX) begin : g_index
            localparam logic [IDX_W-1:0] IDX_VAL = IDX_W'(TABLE_IDX);
            assign vec_word = {{(DATA_W-IDX_W){1'b0}}, IDX_VAL};
        end else begin : g_full
            assign vec_word = DATA_W'(VECTOR_ADDR);
        end
    endgenerate

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_OVR_BIT]  = overrun;
        stat_word[STAT_PEND_BIT] = pending;
    end

    always_comb begin
        vec_sel  = irq_ack && pending;
        hit_data = bus_rd && (bus_addr == BASE_ADDR);
        hit_stat = bus_rd && (bus_addr == STAT_ADDR);
        data_rd  = hit_data && !vec_sel;
        bus_oe    = 1'b0;
        bus_rdata = '0;
        if (vec_sel) begin
            bus_oe    = 1'b1;
            bus_rdata = vec_word;
        end else if (hit_data) begin
            bus_oe    = 1'b1;
            bus_rdata = data_q;
        end else if (hit_stat) begin
            bus_oe    = 1'b1;
            bus_rdata = stat_word;
        end
    end

    // R11
    quiet_bus_chk: assert final (bus_oe || bus_rdata == '0);
endmodule

// File: rtl/vecirq_periph.sv
module vecirq_periph #(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h8000,
    parameter bit                USE_INDEX   = 1'b0,
    parameter int                VECTOR_ADDR = 16,
    parameter int                IDX_W       = 4,
    parameter int                TABLE_IDX   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    output logic              irq_req,
    input  logic              irq_ack
);
    logic              pending;
    logic              data_rd;
    logic              overrun;
    logic [DATA_W-1:0] data_q;

    vip_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_stb (din_stb),
        .data_rd (data_rd),
        .pending (pending)
    );

    vip_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .din_stb   (din_stb),
        .pending   (pending),
        .data_rd   (data_rd),
        .data_q    (data_q),
        .overrun_q (overrun)
    );

    vip_bus_drv #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR),
        .USE_INDEX   (USE_INDEX),
        .VECTOR_ADDR (VECTOR_ADDR),
        .IDX_W       (IDX_W),
        .TABLE_IDX   (TABLE_IDX)
    ) u_bus (
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .irq_ack   (irq_ack),
        .pending   (pending),
        .overrun   (overrun),
        .data_q    (data_q),
        .bus_rdata (bus_rdata),
        .bus_oe    (bus_oe),
        .data_rd   (data_rd)
    );

    assign irq_req = pending;

    // R4
    ack_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |-> bus_oe);
    // R6
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !bus_rd) |-> !bus_oe);
    // R12
    ack_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> irq_req);
    // R2
    read_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_stb |=> ((bus_rd && bus_addr == BASE_ADDR && !irq_ack) -> (bus_rdata == $past(din))));
endmodule

// File: tb/test_vecirq_periph.sv
module test_vecirq_periph;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h8000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] din;
    logic          din_stb;
    logic [AW-1:0] bus_addr;
    logic          bus_rd;
    logic          irq_ack;
    logic [DW-1:0] bus_rdata, bus_rdata_x;
    logic          bus_oe, bus_oe_x, irq_req, irq_req_x;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vecirq_periph #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE),
                    .USE_INDEX(1'b0), .VECTOR_ADDR(16)) i_vecirq_periph (
        .clk(clk), .rst_n(rst_n), .din(din), .din_stb(din_stb),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_oe(bus_oe), .irq_req(irq_req), .irq_ack(irq_ack));

    vecirq_periph #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE),
                    .USE_INDEX(1'b1), .IDX_W(4), .TABLE_IDX(5)) i_vecirq_periph_idx (
        .clk(clk), .rst_n(rst_n), .din(din), .din_stb(din_stb),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata_x),
        .bus_oe(bus_oe_x), .irq_req(irq_req_x), .irq_ack(irq_ack));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        din_stb = 0; bus_rd = 0; irq_ack = 0; bus_addr = 16'h0000;
    endtask

    task automatic strobe(input logic [DW-1:0] v);
        @(negedge clk);
        din = v; din_stb = 1; bus_rd = 0; irq_ack = 0;
        @(negedge clk);
        din_stb = 0;
    endtask

    // read at address; returns comb data and oe, then completes the edge
    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #5;
        d = bus_rdata; oe = bus_oe;
        @(negedge clk);
        bus_rd = 0; bus_addr = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; din_stb = 0; bus_rd = 0; irq_ack = 0; din = '0; bus_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d; logic oe;
        do_reset();
        #5;
        chk(irq_req == 0, "R1 irq after reset", irq_req, 0);
        chk(bus_oe == 0 && bus_rdata == 0, "R11 idle bus", bus_rdata, 0);
        rd(BASE, d, oe);
        chk(d == 0 && oe, "R1 data after reset", d, 0);
        rd(BASE + 1, d, oe);
        chk(d == 0, "R1 status after reset", d, 0);
    endtask

    task automatic t_capture();
        logic [DW-1:0] d; logic oe;
        @(negedge clk);
        din = 8'hA5; din_stb = 1;
        #5;
        chk(irq_req == 0, "R3 irq before edge", irq_req, 0);
        @(posedge clk); #1;
        chk(irq_req == 1, "R3 irq after edge", irq_req, 1);
        @(negedge clk); din_stb = 0;
        rd(BASE + 1, d, oe);
        chk(d == 8'h02, "R10 status pending", d, 8'h02);
    endtask

    task automatic t_ack();
        @(negedge clk);
        irq_ack = 1;
        #5;
        chk(bus_oe && bus_rdata == 8'd16, "R4 full vector", bus_rdata, 16);
        chk(bus_oe_x && bus_rdata_x == 8'd5, "R5 table index", bus_rdata_x, 5);
        @(negedge clk);
        bus_rd = 1; bus_addr = BASE;
        #5;
        chk(bus_rdata == 8'd16, "R12 vector over data", bus_rdata, 16);
        @(negedge clk);
        bus_rd = 0; irq_ack = 0; bus_addr = '0;
        #5;
        chk(irq_req == 1, "R12 request kept", irq_req, 1);
    endtask

    task automatic t_read_clear();
        logic [DW-1:0] d; logic oe;
        @(negedge clk);
        bus_addr = BASE; bus_rd = 1;
        #5;
        chk(oe_ok(bus_oe) && bus_rdata == 8'hA5, "R2 data read", bus_rdata, 8'hA5);
        chk(irq_req == 1, "R7 irq held until edge", irq_req, 1);
        @(posedge clk); #1;
        chk(irq_req == 0, "R7 irq cleared", irq_req, 0);
        idle();
        irq_ack = 1;
        #5;
        chk(!bus_oe && bus_rdata == 0, "R6 ack without request", bus_rdata, 0);
        idle();
        rd(16'h1234, d, oe);
        chk(!oe && d == 0, "R11 foreign address", d, 0);
    endtask

    function automatic bit oe_ok(input logic o);
        return o == 1'b1;
    endfunction

    task automatic t_simul();
        logic [DW-1:0] d; logic oe;
        strobe(8'h44);
        @(negedge clk);
        bus_addr = BASE; bus_rd = 1; din = 8'h55; din_stb = 1;
        #5;
        chk(bus_rdata == 8'h44, "R9 old word returned", bus_rdata, 8'h44);
        @(negedge clk);
        bus_rd = 0; din_stb = 0; bus_addr = '0;
        #5;
        chk(irq_req == 1, "R9 still pending", irq_req, 1);
        rd(BASE + 1, d, oe);
        chk(d == 8'h02, "R9 no overrun", d, 8'h02);
    endtask

    task automatic t_overrun();
        logic [DW-1:0] d; logic oe;
        strobe(8'h66);
        #5;
        chk(irq_req == 1, "R8 request kept", irq_req, 1);
        rd(BASE + 1, d, oe);
        chk(d == 8'h03, "R8 overrun flag", d, 8'h03);
        rd(BASE, d, oe);
        chk(d == 8'h66, "R8 overwritten data", d, 8'h66);
        rd(BASE + 1, d, oe);
        chk(d == 8'h01, "R10 overrun sticky", d, 8'h01);
        do_reset();
        rd(BASE + 1, d, oe);
        chk(d == 8'h00, "R1 reset clears overrun", d, 0);
    endtask

    initial begin
        rst_n = 0; din = '0; din_stb = 0; bus_addr = '0; bus_rd = 0; irq_ack = 0;
        t_reset();
        t_capture();
        t_ack();
        t_read_clear();
        t_simul();
        t_overrun();
        idle();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule